// File: doc/BRIEF.md
# Direct-Page Instruction Bus Sequencer

This block produces the external bus traffic of an 8-bit processor core while it runs instructions whose operand sits in the first 256 bytes of memory. One operand byte follows the opcode and gives the low half of the effective address, and the upper half is always zero. Each clock is one bus cycle. The block drives a 16-bit address, a read/write strobe (high for read) and an 8-bit write-data bus. It samples the read-data bus at the end of each cycle. Memory must answer within the cycle.

The instructions covered are 16-bit loads and stores of the accumulator pair D, the index registers X and Y and the stack pointer, plus 16-bit add and subtract into D, compares of D, X and Y, and the subroutine call. A prefix byte selects the Y forms, and a second prefix byte selects the D compare. Loaded words are written into the register file, and stores take their data from it. A byte that is not a recognised opcode raises a one-cycle error flag and is skipped.

Top module: `dseq_top`

## Requirements
- R1: On every operand-data cycle the address high byte is $00 and the low byte is the fetched operand byte. The second data byte is at that address plus one as a 16-bit sum, so operand $FF gives $0100.
- R2: A load takes 4 cycles, all reads: opcode at PC, operand byte at PC+1, high data at EA, low data at EA+1. The opcodes are $DC (D), $DE (X) and $9E (SP). The register holds {high,low} from the cycle after the last one.
- R3: A store takes 4 cycles. Two fetch reads are followed by two writes (strobe low): high byte to EA, then low byte to EA+1. The opcodes are $DD (D), $DF (X) and $9F (SP).
- R4: Prefix $18 followed by $DE loads Y and by $DF stores Y. Each takes 5 cycles: prefix at PC, second byte at PC+1, operand byte at PC+2, then the two data cycles.
- R5: Add ($D3), subtract ($93) and X compare ($9C) take 5 cycles. The fifth cycle is a read at $FFFF. Add and subtract leave D = (D ± M) mod 2^16, and the compare changes no register.
- R6: The compares $1A $93 (D) and $18 $9C (Y) take 6 cycles, and the last is a read at $FFFF. No instruction lasts more than 6 cycles.
- R7: The call ($9D) takes 5 cycles. It fetches the opcode and the operand byte, reads at EA, writes the low byte of (opcode address + 2) at SP, then writes its high byte at SP-1.
- R8: After the call, SP is 2 lower and PC equals EA.
- R9: After any other completed instruction, PC advances by its length: 2 bytes, or 3 with a prefix.
- R10: An unrecognised byte, or an unrecognised byte after a prefix, causes no write and changes no D, X, Y or SP. PC skips 1 or 2 bytes, and the error flag is high during the next opcode-fetch cycle only.
- R11: In reset, PC = RST_PC ($0100), SP = RST_SP ($01FF), D = X = Y = 0, and the bus shows a read of RST_PC with sync high and the error flag low.
- R12: Sync is high exactly on the first-byte fetch of each instruction, and that cycle is always a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 8 | Read data, valid by the end of each cycle |
| addr | output | 16 | Bus address of the current cycle |
| rw | output | 1 | 1 = read, 0 = write |
| dout | output | 8 | Write data, meaningful when rw is 0 |
| sync | output | 1 | First opcode byte fetched in this cycle |
| bad_op | output | 1 | Previous instruction was unrecognised |
| reg_d | output | 16 | Accumulator pair D |
| reg_x | output | 16 | Index register X |
| reg_y | output | 16 | Index register Y |
| reg_sp | output | 16 | Stack pointer |
| reg_pc | output | 16 | Address of the current instruction |

## Verification
The assertions assume zero-wait memory, so every cycle's read data is valid at the closing edge and the step sequence never stalls. The call check also assumes the call's own stack writes do not overlap the address it reads. The test program keeps operands, code and the stack in separate regions, with one exception. One operand at $FF makes the second data read land on the first code byte at $0100, and that read is part of the expected traffic.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  parameter int DW = 8;
  localparam int AW = 2 * DW;
  localparam int WW = AW;
  localparam int NREG = 4;

  localparam logic [DW-1:0] PFX_Y = 8'h18;
  localparam logic [DW-1:0] PFX_D = 8'h1A;

  typedef enum logic [3:0] {
    ST_OPC, ST_OPC2, ST_ADR, ST_RDH, ST_RDL, ST_INT,
    ST_WRH, ST_WRL, ST_JRD, ST_PSHL, ST_PSHH
  } step_t;

  typedef enum logic [2:0] {K_LOAD, K_STORE, K_ADD, K_SUB, K_CMP, K_CALL, K_NONE} kind_t;
  typedef enum logic [1:0] {G_D, G_X, G_Y, G_S} greg_t;
  typedef enum logic [1:0] {PF_NONE, PF_Y, PF_D} pfx_t;

  typedef struct packed {
    logic  ok;
    kind_t kind;
    greg_t sel;
  } dec_t;

  function automatic logic [WW-1:0] word_add(input logic [WW-1:0] a, input logic [WW-1:0] b);
    return a + b;
  endfunction

  function automatic logic [WW-1:0] word_sub(input logic [WW-1:0] a, input logic [WW-1:0] b);
    return a - b;
  endfunction

  function automatic logic [AW-1:0] page_zero(input logic [DW-1:0] lo);
    return {{(AW-DW){1'b0}}, lo};
  endfunction

  function automatic logic [AW-1:0] link_addr(input logic [AW-1:0] pc);
    return pc + AW'(2);
  endfunction
endpackage

// File: rtl/dseq_decode.sv
module dseq_decode
  import dseq_pkg::*;
(
  input  pfx_t            pfx,
  input  logic [DW-1:0]   code,
  output dec_t            dec
);
  always_comb begin
    dec = '{1'b0, K_NONE, G_D};
    case (pfx)
      PF_NONE: begin
        case (code)
          8'hDC: dec = '{1'b1, K_LOAD,  G_D};
          8'hDD: dec = '{1'b1, K_STORE, G_D};
          8'hDE: dec = '{1'b1, K_LOAD,  G_X};
          8'hDF: dec = '{1'b1, K_STORE, G_X};
          8'h9E: dec = '{1'b1, K_LOAD,  G_S};
          8'h9F: dec = '{1'b1, K_STORE, G_S};
          8'hD3: dec = '{1'b1, K_ADD,   G_D};
          8'h93: dec = '{1'b1, K_SUB,   G_D};
          8'h9C: dec = '{1'b1, K_CMP,   G_X};
          8'h9D: dec = '{1'b1, K_CALL,  G_S};
          default: ;
        endcase
      end
      PF_Y: begin
        case (code)
          8'hDE: dec = '{1'b1, K_LOAD,  G_Y};
          8'hDF: dec = '{1'b1, K_STORE, G_Y};
          8'h9C: dec = '{1'b1, K_CMP,   G_Y};
          default: ;
        endcase
      end
      PF_D: begin
        if (code == 8'h93) dec = '{1'b1, K_CMP, G_D};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dseq_bus.sv
module dseq_bus
  import dseq_pkg::*;
(
  input  step_t           step,
  input  pfx_t            pfx,
  input  logic [AW-1:0]   pc,
  input  logic [DW-1:0]   ea_lo,
  input  logic [AW-1:0]   sp,
  input  logic [WW-1:0]   st_val,
  output logic [AW-1:0]   addr,
  output logic            rw,
  output logic [DW-1:0]   dout
);
  logic [AW-1:0] ea_w;
  logic [AW-1:0] link;

  assign ea_w = page_zero(ea_lo);
  assign link = link_addr(pc);

  always_comb begin
    addr = pc;
    rw   = 1'b1;
    dout = '0;
    case (step)
      ST_OPC:  addr = pc;
      ST_OPC2: addr = pc + AW'(1);
      ST_ADR:  addr = (pfx == PF_NONE) ? pc + AW'(1) : pc + AW'(2);
      ST_RDH:  addr = ea_w;
      ST_RDL:  addr = ea_w + AW'(1);
      ST_INT:  addr = '1;
      ST_JRD:  addr = ea_w;
      ST_WRH: begin addr = ea_w;           rw = 1'b0; dout = st_val[WW-1:DW]; end
      ST_WRL: begin addr = ea_w + AW'(1);  rw = 1'b0; dout = st_val[DW-1:0]; end
      ST_PSHL: begin addr = sp;            rw = 1'b0; dout = link[DW-1:0]; end
      ST_PSHH: begin addr = sp - AW'(1);   rw = 1'b0; dout = link[AW-1:DW]; end
      default: addr = pc;
    endcase
  end
endmodule

// File: rtl/dseq_regs.sv
module dseq_regs
  import dseq_pkg::*;
#(
  parameter logic [AW-1:0] RST_PC = 16'h0100,
  parameter logic [AW-1:0] RST_SP = 16'h01FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  greg_t           wr_sel,
  input  logic [WW-1:0]   wr_val,
  input  logic            pc_we,
  input  logic [AW-1:0]   pc_nxt,
  input  greg_t           rd_sel,
  output logic [WW-1:0]   rd_val,
  output logic [AW-1:0]   pc,
  output logic [WW-1:0]   d,
  output logic [WW-1:0]   x,
  output logic [WW-1:0]   y,
  output logic [WW-1:0]   sp
);
  logic [WW-1:0] gr [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [WW-1:0] INIT = (g == int'(G_S)) ? WW'(RST_SP) : '0;
    logic [WW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               q <= INIT;
      else if (wr_en && wr_sel == greg_t'(g))   q <= wr_val;
    end
    assign gr[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc <= RST_PC;
    else if (pc_we) pc <= pc_nxt;
  end

  assign rd_val = gr[rd_sel];
  assign d  = gr[G_D];
  assign x  = gr[G_X];
  assign y  = gr[G_Y];
  assign sp = gr[G_S];
endmodule

// File: rtl/dseq_top.sv
module dseq_top
  import dseq_pkg::*;
#(
  parameter logic [AW-1:0] RST_PC = 16'h0100,
  parameter logic [AW-1:0] RST_SP = 16'h01FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   din,
  output logic [AW-1:0]   addr,
  output logic            rw,
  output logic [DW-1:0]   dout,
  output logic            sync,
  output logic            bad_op,
  output logic [WW-1:0]   reg_d,
  output logic [WW-1:0]   reg_x,
  output logic [WW-1:0]   reg_y,
  output logic [AW-1:0]   reg_sp,
  output logic [AW-1:0]   reg_pc
);
  step_t         step_q, step_d;
  pfx_t          pfx_q, dec_pfx;
  kind_t         kind_q;
  greg_t         sel_q, wr_sel;
  logic [DW-1:0] ea_q, hi_q, lo_q;
  logic          bad_q, bad_now;
  logic [2:0]    run_q;
  dec_t          dec;
  logic          wr_en, pc_we;
  logic [WW-1:0] wr_val, st_val, opnd;
  logic [AW-1:0] pc_nxt, ins_len;
  logic          is_pfx;

  assign dec_pfx = (step_q == ST_OPC) ? PF_NONE : pfx_q;
  assign is_pfx  = (din == PFX_Y) || (din == PFX_D);
  assign ins_len = (pfx_q == PF_NONE) ? AW'(2) : AW'(3);
  assign opnd    = {hi_q, lo_q};

  dseq_decode u_dec (.pfx(dec_pfx), .code(din), .dec(dec));

  dseq_regs #(.RST_PC(RST_PC), .RST_SP(RST_SP)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_val(wr_val),
    .pc_we(pc_we), .pc_nxt(pc_nxt),
    .rd_sel(sel_q), .rd_val(st_val),
    .pc(reg_pc), .d(reg_d), .x(reg_x), .y(reg_y), .sp(reg_sp)
  );

  dseq_bus u_bus (
    .step(step_q), .pfx(pfx_q), .pc(reg_pc), .ea_lo(ea_q), .sp(reg_sp),
    .st_val(st_val), .addr(addr), .rw(rw), .dout(dout)
  );

  always_comb begin
    step_d  = step_q;
    wr_en   = 1'b0;
    wr_sel  = sel_q;
    wr_val  = '0;
    pc_we   = 1'b0;
    pc_nxt  = reg_pc + ins_len;
    bad_now = 1'b0;
    case (step_q)
      ST_OPC: begin
        if (is_pfx)      step_d = ST_OPC2;
        else if (dec.ok) step_d = ST_ADR;
        else begin
          bad_now = 1'b1;
          pc_we   = 1'b1;
          pc_nxt  = reg_pc + AW'(1);
        end
      end
      ST_OPC2: begin
        if (dec.ok) step_d = ST_ADR;
        else begin
          bad_now = 1'b1;
          pc_we   = 1'b1;
          pc_nxt  = reg_pc + AW'(2);
          step_d  = ST_OPC;
        end
      end
      ST_ADR: begin
        case (kind_q)
          K_STORE: step_d = ST_WRH;
          K_CALL:  step_d = ST_JRD;
          default: step_d = ST_RDH;
        endcase
      end
      ST_RDH: step_d = ST_RDL;
      ST_RDL: begin
        if (kind_q == K_LOAD) begin
          wr_en  = 1'b1;
          wr_val = {hi_q, din};
          pc_we  = 1'b1;
          step_d = ST_OPC;
        end else begin
          step_d = ST_INT;
        end
      end
      ST_INT: begin
        wr_sel = G_D;
        wr_en  = (kind_q == K_ADD) || (kind_q == K_SUB);
        wr_val = (kind_q == K_ADD) ? word_add(reg_d, opnd) : word_sub(reg_d, opnd);
        pc_we  = 1'b1;
        step_d = ST_OPC;
      end
      ST_WRH: step_d = ST_WRL;
      ST_WRL: begin
        pc_we  = 1'b1;
        step_d = ST_OPC;
      end
      ST_JRD:  step_d = ST_PSHL;
      ST_PSHL: step_d = ST_PSHH;
      ST_PSHH: begin
        wr_en  = 1'b1;
        wr_sel = G_S;
        wr_val = reg_sp - WW'(2);
        pc_we  = 1'b1;
        pc_nxt = page_zero(ea_q);
        step_d = ST_OPC;
      end
      default: step_d = ST_OPC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_OPC;
      pfx_q  <= PF_NONE;
      kind_q <= K_NONE;
      sel_q  <= G_D;
      ea_q   <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      bad_q  <= 1'b0;
      run_q  <= '0;
    end else begin
      step_q <= step_d;
      bad_q  <= bad_now;
      run_q  <= (step_d == ST_OPC) ? 3'd0 : run_q + 3'd1;
      case (step_q)
        ST_OPC: begin
          if (din == PFX_Y)      pfx_q <= PF_Y;
          else if (din == PFX_D) pfx_q <= PF_D;
          else                   pfx_q <= PF_NONE;
          if (dec.ok) begin
            kind_q <= dec.kind;
            sel_q  <= dec.sel;
          end
        end
        ST_OPC2: begin
          if (dec.ok) begin
            kind_q <= dec.kind;
            sel_q  <= dec.sel;
          end
        end
        ST_ADR: ea_q <= din;
        ST_RDH: hi_q <= din;
        ST_RDL: lo_q <= din;
        default: ;
      endcase
    end
  end

  assign sync   = (step_q == ST_OPC);
  assign bad_op = bad_q;

  // R1
  ea_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q inside {ST_RDH, ST_WRH, ST_JRD}) |-> (addr[AW-1:DW] == '0));

  // R3
  wr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rw && step_q == ST_WRH) |=> (!rw && addr == $past(addr) + AW'(1)));

  // R5
  int_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_INT) |-> (rw && addr == '1));

  // R6
  len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 3'd5);

  // R8
  call_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_PSHH) |=> (reg_sp == $past(reg_sp) - AW'(2) && reg_pc == page_zero($past(ea_q))));

  // R10
  bad_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |-> sync);

  // R12
  sync_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> (rw && run_q == 3'd0));
endmodule

// File: tb/dseq_top_test.sv
module dseq_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  din;
  logic [15:0] addr;
  logic        rw;
  logic [7:0]  dout;
  logic        sync, bad_op;
  logic [15:0] reg_d, reg_x, reg_y, reg_sp, reg_pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] mem [512];
  int mm [512];

  int qa[$], qw[$], qd[$], qs[$], qb[$];
  string qt[$];

  int e_reg[4], v_reg[4];
  int e_pc, v_pc;
  string e_tag, v_tag, e_ptag, v_ptag;
  int pend_bad;
  int pp;

  always #2 clk = ~clk;

  dseq_top uut (
    .clk(clk), .rst_n(rst_n), .din(din), .addr(addr), .rw(rw), .dout(dout),
    .sync(sync), .bad_op(bad_op), .reg_d(reg_d), .reg_x(reg_x), .reg_y(reg_y),
    .reg_sp(reg_sp), .reg_pc(reg_pc)
  );

  assign din = mem[addr[8:0]];

  always @(posedge clk) if (rst_n && !rw) mem[addr[8:0]] <= dout;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int rd(input int a);
    return mm[a & 511];
  endfunction

  task automatic put(input int a, input int v);
    mem[a & 511] <= v[7:0];
    mm[a & 511] = v & 255;
  endtask

  task automatic emit(input int v);
    put(pp, v);
    pp++;
  endtask

  task automatic push(input int a, input int w, input int d, input int s, input int b, input string t);
    qa.push_back(a & 16'hFFFF); qw.push_back(w); qd.push_back(d & 255);
    qs.push_back(s); qb.push_back(b); qt.push_back(t);
  endtask

  // behavioural model of one instruction: queues its bus cycles, computes final registers
  task automatic plan_next();
    int p, op, pf, key, k, r, alen, ea, hi, lb, m, ret, s;
    p = e_pc; op = rd(p); pf = 0; alen = 2; k = -1; r = 0;
    push(p, 1, 0, 1, pend_bad, "R12");
    pend_bad = 0;
    if (op == 8'h18 || op == 8'h1A) begin
      pf = op; op = rd(p + 1); alen = 3;
      push(p + 1, 1, 0, 0, 0, "R4");
    end
    key = pf * 256 + op;
    case (key)
      16'h00DC: begin k = 0; r = 0; end
      16'h00DE: begin k = 0; r = 1; end
      16'h009E: begin k = 0; r = 3; end
      16'h18DE: begin k = 0; r = 2; end
      16'h00DD: begin k = 1; r = 0; end
      16'h00DF: begin k = 1; r = 1; end
      16'h009F: begin k = 1; r = 3; end
      16'h18DF: begin k = 1; r = 2; end
      16'h00D3: k = 2;
      16'h0093: k = 3;
      16'h009C: k = 4;
      16'h1A93: k = 4;
      16'h189C: k = 4;
      16'h009D: k = 5;
      default:  k = -1;
    endcase
    if (k < 0) begin  // R10
      pend_bad = 1;
      e_pc = (p + alen - 1) & 16'hFFFF;
      e_tag = "R10"; e_ptag = "R10";
      return;
    end
    ea = rd(p + alen - 1);
    push(p + alen - 1, 1, 0, 0, 0, (pf != 0) ? "R4" : "R1");
    e_pc = (p + alen) & 16'hFFFF;
    e_ptag = "R9";
    case (k)
      0: begin
        hi = rd(ea); lb = rd(ea + 1);
        push(ea, 1, 0, 0, 0, "R1");
        push(ea + 1, 1, 0, 0, 0, (pf != 0) ? "R4" : "R2");
        e_reg[r] = hi * 256 + lb; e_tag = "R2";
      end
      1: begin
        m = e_reg[r];
        push(ea, 0, m >> 8, 0, 0, "R3");
        push(ea + 1, 0, m, 0, 0, (pf != 0) ? "R4" : "R3");
        mm[ea & 511] = (m >> 8) & 255; mm[(ea + 1) & 511] = m & 255;
        e_tag = "R3";
      end
      2, 3, 4: begin
        hi = rd(ea); lb = rd(ea + 1);
        push(ea, 1, 0, 0, 0, "R5");
        push(ea + 1, 1, 0, 0, 0, "R5");
        push(16'hFFFF, 1, 0, 0, 0, (pf != 0) ? "R6" : "R5");
        m = hi * 256 + lb;
        if (k == 2) e_reg[0] = (e_reg[0] + m) & 16'hFFFF;
        if (k == 3) e_reg[0] = (e_reg[0] - m) & 16'hFFFF;
        e_tag = "R5";
      end
      default: begin
        push(ea, 1, 0, 0, 0, "R7");
        ret = (p + 2) & 16'hFFFF; s = e_reg[3];
        push(s, 0, ret, 0, 0, "R7");
        push((s - 1) & 16'hFFFF, 0, ret >> 8, 0, 0, "R7");
        mm[s & 511] = ret & 255; mm[(s - 1) & 511] = (ret >> 8) & 255;
        e_reg[3] = (s - 2) & 16'hFFFF; e_pc = ea;
        e_tag = "R8"; e_ptag = "R8";
      end
    endcase
  endtask

  task automatic load_program();
    for (int i = 0; i < 512; i++) put(i, 0);
    put(16'h10, 8'h12); put(16'h11, 8'h34);
    put(16'h12, 8'hAB); put(16'h13, 8'hCD);
    put(16'h14, 8'h01); put(16'h15, 8'hF0);
    pp = 16'h100;
    emit(8'hDC); emit(8'h10);                // load D
    emit(8'hDE); emit(8'h12);                // load X
    emit(8'h18); emit(8'hDE); emit(8'h10);   // load Y
    emit(8'hD3); emit(8'h12);                // add
    emit(8'h93); emit(8'h10);                // subtract
    emit(8'h9C); emit(8'h10);                // compare X
    emit(8'h1A); emit(8'h93); emit(8'h10);   // compare D
    emit(8'h18); emit(8'h9C); emit(8'h12);   // compare Y
    emit(8'hDD); emit(8'h30);                // store D
    emit(8'hDF); emit(8'h32);                // store X
    emit(8'h18); emit(8'hDF); emit(8'h34);   // store Y
    emit(8'h9F); emit(8'h36);                // store SP
    emit(8'h9E); emit(8'h14);                // load SP
    emit(8'hDC); emit(8'h30);                // load D back
    emit(8'h41);                             // undefined
    emit(8'h18); emit(8'h41);                // undefined after prefix
    emit(8'hD3); emit(8'hFF);                // add across page edge
    emit(8'h93); emit(8'h12);                // subtract with borrow
    emit(8'h9D); emit(8'h40);                // call
    pp = 16'h40;
    emit(8'hDE); emit(8'h10);
    emit(8'h9D); emit(8'h50);
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    load_program();
    for (int i = 0; i < 4; i++) e_reg[i] = 0;
    e_reg[3] = 16'h01FF; e_pc = 16'h0100;
    e_tag = "R11"; e_ptag = "R11"; pend_bad = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(sync == 1'b1, "R11", "sync in reset", sync, 1);
    chk(rw == 1'b1, "R11", "rw in reset", rw, 1);
    chk(addr == 16'h0100, "R11", "addr in reset", addr, 16'h0100);
    chk(bad_op == 1'b0, "R11", "bad_op in reset", bad_op, 0);
    chk(reg_pc == 16'h0100, "R11", "pc in reset", reg_pc, 16'h0100);
    chk(reg_sp == 16'h01FF, "R11", "sp in reset", reg_sp, 16'h01FF);
    chk(reg_d == 0 && reg_x == 0 && reg_y == 0, "R11", "d|x|y in reset", reg_d | reg_x | reg_y, 0);
    for (int c = 0; c < 420; c++) begin
      int ea_, ew, ed, es, eb;
      string et;
      @(negedge clk);
      if (c == 0) rst_n = 1'b1;
      if (qa.size() == 0) begin
        for (int i = 0; i < 4; i++) v_reg[i] = e_reg[i];
        v_pc = e_pc; v_tag = e_tag; v_ptag = e_ptag;
        plan_next();
      end
      ea_ = qa.pop_front(); ew = qw.pop_front(); ed = qd.pop_front();
      es = qs.pop_front(); eb = qb.pop_front(); et = qt.pop_front();
      chk(addr == ea_[15:0], et, "addr", addr, ea_);
      chk(rw == ew[0], et, "rw", rw, ew);
      if (ew == 0) chk(dout == ed[7:0], et, "dout", dout, ed);
      chk(sync == es[0], "R12", "sync", sync, es);
      chk(bad_op == eb[0], "R10", "bad_op", bad_op, eb);
      chk(reg_d == v_reg[0][15:0], v_tag, "reg_d", reg_d, v_reg[0]);
      chk(reg_x == v_reg[1][15:0], v_tag, "reg_x", reg_x, v_reg[1]);
      chk(reg_y == v_reg[2][15:0], v_tag, "reg_y", reg_y, v_reg[2]);
      chk(reg_sp == v_reg[3][15:0], v_tag, "reg_sp", reg_sp, v_reg[3]);
      chk(reg_pc == v_pc[15:0], v_ptag, "reg_pc", reg_pc, v_pc);
    end
    // R3 and R7: memory contents written by stores and pushes
    for (int a = 16'h30; a < 16'h38; a++)
      chk(int'(mem[a]) == mm[a], "R3", "stored byte", mem[a], mm[a]);
    for (int a = 16'h1E0; a < 16'h200; a++)
      chk(int'(mem[a]) == mm[a], "R7", "stack byte", mem[a], mm[a]);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule